// File: doc/BRIEF.md
# Double-Buffered Auto-Repeat SPI Master

This block is an SPI master shift engine that moves 32-bit words MSB first. Software reaches it through a small register port: a write strobe with address and data, and a read address with combinational read data. A one-entry transmit holding register sits in front of the active shift register. In the plain mode, software writes a word and issues a start command for each transfer. In the buffered mode, a word written while a transfer is running waits in the holding register. It is loaded into the shift register as soon as the current transfer ends, so transfers run back to back for as long as software keeps the holding register filled. When the holding register is empty at the end of a transfer, the engine pauses. It resumes by itself when the next word arrives.

A second lane pair (MOSI1/MISO1) can shift its own word alongside lane 0. SCLK comes from the system clock through a programmable divider. A programmable idle gap, counted in whole SCLK periods, separates consecutive buffered transfers. Each finished transfer sets a flag that drives the interrupt pin when enabled, and software clears the flag by writing 1 to it.

Top module: `spi_dbuf_master`

## Requirements
- R1: Every completed transfer sets the done flag (STATUS bit 0) in the cycle the transfer ends. The `irq` output equals the done flag ANDed with the interrupt-enable bit (CTRL bit 5).
- R2: Writing STATUS with bit 0 = 1 clears the done flag. Writing STATUS with bit 0 = 0 leaves the flag unchanged.
- R3: With buffered mode off (CTRL bit 1 = 0), writing CTRL with bit 0 = 1 while idle starts one transfer of the TX0 word. A write to TX0 (address 2) or TX1 (address 3) while a transfer is shifting is ignored.
- R4: With buffered mode on, a TX0 write is accepted at any time into the holding register. A pending word is loaded into the shift register when the current transfer ends, so transfers chain with no software start.
- R5: A word written to TX0 before buffered mode is enabled starts a transfer as soon as CTRL bit 1 is set.
- R6: In buffered mode, the engine stays idle when no word is pending at the end of a transfer (STATUS bit 2 busy = 0), and it starts again once TX0 is written.
- R7: Clearing CTRL bit 1 during a transfer lets that transfer finish. No further transfer starts, even with a word pending (STATUS bit 1 = 1).
- R8: In buffered mode, after a transfer ends the engine idles for GAP (address 7) × SCLK period, followed by one start cycle. Slave-select therefore stays inactive for 2·GAP·(DIV+1)+1 system clocks between chained transfers.
- R9: With CTRL bit 2 set, lane 1 shifts TX1 out on `mosi1` and captures `miso1` into RX1 (address 5) at the same time as lane 0.
- R10: Each transfer is 32 bits, MSB first. Data changes on the trailing SCLK edge and is sampled on the leading edge. SCLK idles at CTRL bit 3. `ss` equals CTRL bit 4 during a transfer and its inverse otherwise.
- R11: RX0 (address 4) takes the received lane-0 word when each transfer ends and keeps it until the next transfer ends.
- R12: The SCLK period is 2·(DIV+1) system clocks, where DIV is written at address 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sclk | output | 1 | Serial clock |
| ss | output | 1 | Slave select |
| mosi0 | output | 1 | Lane 0 serial output |
| miso0 | input | 1 | Lane 0 serial input |
| mosi1 | output | 1 | Lane 1 serial output |
| miso1 | input | 1 | Lane 1 serial input |
| irq | output | 1 | Transfer-done interrupt |

## Verification
A register write takes effect at the next clock edge. A transfer therefore asserts `ss` one cycle after its start command, or one cycle after the holding word becomes pending in buffered mode. The done flag, the `irq` pin, RX0/RX1 and the deassertion of `ss` all change at the same edge, which ends the last SCLK period. The bench follows `ss`, `sclk`, `irq` and the data lines at every falling system-clock edge, half a cycle away from the edge where they change. It compares them each cycle against a behavioural slave-and-flag model. It reads registers only after a watched `ss` deassertion, and it measures the chain gap and the SCLK period as counts of falling edges. Those counts are then compared with the closed-form values in R8 and R12.

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              sclk,
  output logic              ss,
  output logic              mosi0,
  input  logic              miso0,
  output logic              mosi1,
  input  logic              miso1,
  output logic              irq
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TX0 = 3'd2, A_TX1 = 3'd3,
                         A_RX0 = 3'd4, A_RX1 = 3'd5, A_DIV = 3'd6, A_GAP = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} st_t;
  st_t st;

  logic buf_mode, two_lane, cpol, ss_hi, ie, flag, hold_vld, sck;
  logic [DIV_W-1:0]  div_q, cnt;
  logic [GAP_W-1:0]  gap_q;
  logic [GAP_W:0]    ghalf;
  logic [CNT_W-1:0]  bitcnt;
  logic [WORD_W-1:0] hold0, hold1, sh0, sh1, rsh0, rsh1, rx0, rx1;

  wire idle     = (st == ST_IDLE);
  wire shifting = (st == ST_SHIFT);
  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire clr_req  = reg_wr && reg_addr == A_STAT && reg_wdata[0];
  wire tx_ok    = buf_mode || !shifting;
  wire wr_tx0   = reg_wr && reg_addr == A_TX0 && tx_ok;
  wire wr_tx1   = reg_wr && reg_addr == A_TX1 && tx_ok;
  wire go       = wr_ctrl && reg_wdata[0] && idle && !buf_mode;
  wire start    = go || (idle && buf_mode && hold_vld);
  wire tick     = shifting && cnt == '0;
  wire done     = tick && sck && bitcnt == LAST_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      buf_mode <= 1'b0; two_lane <= 1'b0; cpol <= 1'b0; ss_hi <= 1'b0; ie <= 1'b0;
      div_q <= '0; gap_q <= '0; cnt <= '0; ghalf <= '0; bitcnt <= '0;
      flag <= 1'b0; hold_vld <= 1'b0; sck <= 1'b0;
      hold0 <= '0; hold1 <= '0; sh0 <= '0; sh1 <= '0;
      rsh0 <= '0; rsh1 <= '0; rx0 <= '0; rx1 <= '0;
    end else begin
      if (wr_ctrl) begin
        buf_mode <= reg_wdata[1];
        two_lane <= reg_wdata[2];
        cpol     <= reg_wdata[3];
        ss_hi    <= reg_wdata[4];
        ie       <= reg_wdata[5];
      end
      if (reg_wr && reg_addr == A_DIV) div_q <= reg_wdata[DIV_W-1:0];
      if (reg_wr && reg_addr == A_GAP) gap_q <= reg_wdata[GAP_W-1:0];
      if (wr_tx1) hold1 <= reg_wdata;
      if (wr_tx0) begin
        hold0    <= reg_wdata;
        hold_vld <= 1'b1;
      end else if (start) begin
        hold_vld <= 1'b0;
      end
      if (done) flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;

      case (st)
        ST_IDLE: if (start) begin
          st <= ST_SHIFT;
          sh0 <= hold0;
          sh1 <= hold1;
          sck <= 1'b0;
          cnt <= div_q;
          bitcnt <= '0;
        end
        ST_SHIFT: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= div_q;
          if (!sck) begin
            sck  <= 1'b1;
            rsh0 <= {rsh0[WORD_W-2:0], miso0};
            rsh1 <= {rsh1[WORD_W-2:0], miso1};
          end else begin
            sck <= 1'b0;
            if (bitcnt == LAST_BIT) begin
              rx0 <= rsh0;
              if (two_lane) rx1 <= rsh1;
              if (buf_mode && gap_q != '0) begin
                st <= ST_GAP;
                ghalf <= {gap_q, 1'b0};
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              sh0 <= {sh0[WORD_W-2:0], 1'b0};
              sh1 <= {sh1[WORD_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_GAP: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= div_q;
          if (ghalf == (GAP_W+1)'(1)) st <= ST_IDLE;
          else ghalf <= ghalf - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(WORD_W-6){1'b0}}, ie, ss_hi, cpol, two_lane, buf_mode, 1'b0};
      A_STAT:  reg_rdata = {{(WORD_W-3){1'b0}}, !idle, hold_vld, flag};
      A_TX0:   reg_rdata = hold0;
      A_TX1:   reg_rdata = hold1;
      A_RX0:   reg_rdata = rx0;
      A_RX1:   reg_rdata = rx1;
      A_DIV:   reg_rdata = {{(WORD_W-DIV_W){1'b0}}, div_q};
      default: reg_rdata = {{(WORD_W-GAP_W){1'b0}}, gap_q};
    endcase
  end

  assign sclk  = sck ^ cpol;
  assign ss    = shifting ? ss_hi : !ss_hi;
  assign mosi0 = shifting && sh0[WORD_W-1];
  assign mosi1 = shifting && two_lane && sh1[WORD_W-1];
  assign irq   = flag && ie;
endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk (
  input logic clk,
  input logic rst_n,
  input logic shifting,
  input logic idle,
  input logic done,
  input logic go,
  input logic clr_req,
  input logic flag,
  input logic hold_vld,
  input logic sclk,
  input logic ss,
  input logic cpol,
  input logic ss_hi
);
  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> flag); // R1
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_req && !done) |=> !flag); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag && !clr_req) |=> flag); // R2
  AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (idle && !hold_vld && !go) |=> !shifting); // R6
  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n) !shifting |-> (sclk == cpol)); // R10
  AST_SS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) shifting |-> (ss == ss_hi)); // R10
endmodule

bind spi_dbuf_master spi_dbuf_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shifting(shifting), .idle(idle), .done(done), .go(go),
  .clr_req(clr_req), .flag(flag), .hold_vld(hold_vld), .sclk(sclk), .ss(ss),
  .cpol(cpol), .ss_hi(ss_hi)
);

// File: tb/spi_dbuf_master_bench.sv
`timescale 1ns/1ps
module spi_dbuf_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, ss, mosi0, mosi1, miso0, miso1, irq;

  spi_dbuf_master u_spi_dbuf_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sclk(sclk), .ss(ss), .mosi0(mosi0), .miso0(miso0),
    .mosi1(mosi1), .miso1(miso1), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, frames = 0, cyc = 0, k = 0, gap_run = 0, last_gap = 0;
  int first_lead = 0, per = 0;
  logic m_flag = 1'b0, m_ie = 1'b0, m_cpol = 1'b0, m_sshi = 1'b0;
  logic act = 1'b0, prev_lead = 1'b0;
  logic [31:0] cap0 = '0, cap1 = '0, slv0 = '0, slv1 = '0, rd;
  logic [31:0] got0[$], got1[$];

  assign miso0 = (k < 32) ? slv0[31-k] : 1'b0;
  assign miso1 = (k < 32) ? slv1[31-k] : 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
    if (a == 3'd0) begin
      m_ie = d[5]; m_cpol = d[3]; m_sshi = d[4];
    end
    if (a == 3'd1 && d[0]) m_flag = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] pop0();
    if (got0.size() == 0) return 32'hDEAD_0000;
    return got0.pop_front();
  endfunction

  // behavioural slave and flag model, compared every clock
  always @(negedge clk) begin
    logic now_act, lead;
    if (rst_n) begin
      cyc++;
      now_act = (ss === m_sshi);
      lead = (sclk !== m_cpol);
      if (now_act && !act) begin
        last_gap = gap_run;
        k = 0;
      end
      if (now_act && lead && !prev_lead) begin
        cap0 = {cap0[30:0], mosi0};
        cap1 = {cap1[30:0], mosi1};
        if (k == 0) first_lead = cyc;
        if (k == 1) per = cyc - first_lead;
        k++;
      end
      if (!now_act && act) begin
        frames++;
        m_flag = 1'b1;
        got0.push_back(cap0);
        got1.push_back(cap1);
        gap_run = 0;
        k = 0;
      end
      if (!now_act) begin
        gap_run++;
        chk(sclk === m_cpol, "R10 sclk parked", {31'd0, sclk}, {31'd0, m_cpol});
      end
      chk(irq === (m_flag & m_ie), "R1 irq pin", {31'd0, irq}, {31'd0, m_flag & m_ie});
      act = now_act;
      prev_lead = now_act && lead;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    rdreg(3'd1, rd);
    chk(rd == 32'd0, "R1 reset status", rd, 32'd0);
    chk(ss === 1'b1 && sclk === 1'b0 && irq === 1'b0, "R10 reset pins", {29'd0, ss, sclk, irq}, 32'h4);

    // plain mode: R3 R10 R11 R12 R1 R2
    wr(3'd6, 32'd1);
    wr(3'd2, 32'hA5A5_0F0F);
    slv0 = 32'h3C3C_1234;
    n = frames;
    wr(3'd0, 32'h21);
    wait (act);
    repeat (20) @(posedge clk);
    wr(3'd2, 32'hFFFF_0000);
    wait (frames == n + 1);
    repeat (3) @(posedge clk);
    rd = pop0();
    chk(rd == 32'hA5A5_0F0F, "R10 msb-first word", rd, 32'hA5A5_0F0F);
    chk(per == 4, "R12 sclk period", per, 32'd4);
    rdreg(3'd4, rd);
    chk(rd == 32'h3C3C_1234, "R11 rx0 word", rd, 32'h3C3C_1234);
    chk(irq === 1'b1, "R1 irq after done", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'd0);
    rdreg(3'd1, rd);
    chk(rd[0] == 1'b1, "R2 write0 keeps flag", rd, 32'd1);
    wr(3'd1, 32'd1);
    rdreg(3'd1, rd);
    chk(rd[0] == 1'b0, "R2 write1 clears flag", rd, 32'd0);
    slv0 = 32'h0000_00FF;
    wr(3'd0, 32'h21);
    wait (frames == n + 2);
    repeat (3) @(posedge clk);
    rd = pop0();
    chk(rd == 32'hA5A5_0F0F, "R3 busy write ignored", rd, 32'hA5A5_0F0F);
    rdreg(3'd4, rd);
    chk(rd == 32'h0000_00FF, "R11 rx0 replaced", rd, 32'h0000_00FF);

    // buffered chain: R5 R4 R8 R6
    wr(3'd7, 32'd2);
    wr(3'd2, 32'h1111_2222);
    n = frames;
    wr(3'd0, 32'h22);
    wait (act);
    chk(frames == n, "R5 prewritten word starts", frames, n);
    repeat (10) @(posedge clk);
    wr(3'd2, 32'h3333_4444);
    wait (frames == n + 1);
    wait (act);
    chk(last_gap == 9, "R8 chain gap", last_gap, 32'd9);
    repeat (10) @(posedge clk);
    wr(3'd2, 32'h5555_6666);
    wait (frames == n + 3);
    repeat (300) @(posedge clk);
    chk(frames == n + 3, "R6 stall when empty", frames, n + 3);
    rdreg(3'd1, rd);
    chk(rd[2:1] == 2'b00, "R6 idle no pending", rd, 32'd0);
    rd = pop0();
    chk(rd == 32'h1111_2222, "R5 first word", rd, 32'h1111_2222);
    rd = pop0();
    chk(rd == 32'h3333_4444, "R4 second word", rd, 32'h3333_4444);
    rd = pop0();
    chk(rd == 32'h5555_6666, "R4 third word", rd, 32'h5555_6666);
    chk(last_gap == 9, "R8 second gap", last_gap, 32'd9);
    wr(3'd2, 32'h7777_8888);
    wait (frames == n + 4);
    repeat (20) @(posedge clk);
    rd = pop0();
    chk(rd == 32'h7777_8888, "R6 resume on write", rd, 32'h7777_8888);

    // leaving buffered mode: R7
    wr(3'd7, 32'd0);
    n = frames;
    wr(3'd2, 32'h9999_AAAA);
    wait (act);
    repeat (10) @(posedge clk);
    wr(3'd2, 32'hBBBB_CCCC);
    repeat (10) @(posedge clk);
    wr(3'd0, 32'h20);
    wait (frames == n + 1);
    repeat (300) @(posedge clk);
    chk(frames == n + 1, "R7 no start after clear", frames, n + 1);
    rdreg(3'd1, rd);
    chk(rd[2:1] == 2'b01, "R7 word left pending", rd, 32'd2);
    rd = pop0();
    chk(rd == 32'h9999_AAAA, "R7 running word finished", rd, 32'h9999_AAAA);

    // two lanes, inverted clock, active-high select: R9 R10
    wr(3'd0, 32'h3C);
    repeat (4) @(posedge clk);
    chk(ss === 1'b0 && sclk === 1'b1, "R10 idle levels", {30'd0, ss, sclk}, 32'd1);
    wr(3'd2, 32'hC0DE_F00D);
    wr(3'd3, 32'h8000_0001);
    slv0 = 32'h1357_9BDF;
    slv1 = 32'hFEDC_BA98;
    got1.delete();
    n = frames;
    wr(3'd0, 32'h3D);
    wait (frames == n + 1);
    repeat (3) @(posedge clk);
    rd = pop0();
    chk(rd == 32'hC0DE_F00D, "R10 lane0 with cpol1", rd, 32'hC0DE_F00D);
    rd = (got1.size() > 0) ? got1.pop_front() : 32'hDEAD_0001;
    chk(rd == 32'h8000_0001, "R9 lane1 word", rd, 32'h8000_0001);
    rdreg(3'd5, rd);
    chk(rd == 32'hFEDC_BA98, "R9 rx1 word", rd, 32'hFEDC_BA98);
    rdreg(3'd4, rd);
    chk(rd == 32'h1357_9BDF, "R11 rx0 lane0", rd, 32'h1357_9BDF);
    finish_run();
  end
endmodule